// File: doc/BRIEF.md
# Host Mailbox Command Sequencer

This block sits on the host side of a doorbell mailbox that connects the host to a boot and service engine. Callers push four-word commands into a small FIFO. The sequencer takes them one at a time. For each command it stamps a wrapping sequence ID into header word 0, forces the acknowledge-request flag, and writes the four words over a simple register bus. It then rings the outbound doorbell. The engine answers through an inbound doorbell register and four response registers. The level interrupt `irq_i` is high while any inbound doorbell bit is set.

While a command is in flight, the sequencer services the inbound doorbell. Each command ends on exactly one completion record. The record carries a status (done, timeout, sequence error or send error), the sequence ID that was used, the primary status code and the response words. If the engine signals that it is back from reset, the doorbell is wiped and the in-flight command is sent again. If sends fail repeatedly, new sends are held back for a while.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, `cpl_valid_o` is 0 and `reg_req_o` is 0.
- R2: Outbound word 0 keeps the command word unchanged, except for two fields. Bits 31:16 carry the sequence ID. Bit 33 (acknowledge request) is forced to 1. Bit 32 is the caller's response-request flag. Words 1 to 3 are sent unchanged. They are written to addresses 0 to 3, and then 1 is written to the doorbell-set address 4.
- R3: The first command gets sequence ID 1. Each command taken from the FIFO gets the next ID. After `SEQ_LAST` the next ID is 1 again.
- R4: No command is written to the mailbox while another is in flight. A command stays in flight until its completion or until a back-from-reset indication.
- R5: Inbound doorbell bit 0 means acknowledge. On acknowledge, a command without the response request completes with status done (code 0). `cpl_valid_o` lasts one cycle.
- R6: Inbound doorbell bit 1 means response. On a response, the four response registers (addresses 5 to 8) are read before bit 1 is cleared. The completion then returns those words, and `cpl_prim_o` equals bits 63:48 of response word 0.
- R7: When the acknowledge and response bits are both pending, the acknowledge bit is cleared first. Bits are cleared by writing ones to address 10, and the doorbell is read at address 9.
- R8: A response whose bits 31:16 differ from the ID that was sent completes with status sequence error (code 2).
- R9: A command that is not completed within `TIMEOUT_CYC` cycles of its doorbell write completes with status timeout (code 1). The next command then goes out.
- R10: Inbound bit 2 means back from reset. It clears every set doorbell bit in one write. The in-flight command is then sent again with the same ID.
- R11: A bus error on any outbound write completes the command with status send error (code 3). After three consecutive failures, no send starts for `PAUSE_CYC` cycles.
- R12: A response bit or an unknown doorbell bit with nothing in flight is cleared and produces no completion.
- R13: At most one register-bus transaction is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word set offered |
| cmd_ready_o | output | 1 | FIFO has room |
| cmd_words_i | input | 256 | Four command words, word 0 in bits 63:0 |
| reg_req_o | output | 1 | One-cycle register-bus request |
| reg_we_o | output | 1 | Request is a write |
| reg_addr_o | output | 4 | Mailbox register address |
| reg_wdata_o | output | 64 | Write data |
| reg_ack_i | input | 1 | Transaction finished |
| reg_err_i | input | 1 | Transaction failed, valid with ack |
| reg_rdata_i | input | 64 | Read data, valid with ack |
| irq_i | input | 1 | Inbound doorbell non-zero |
| cpl_valid_o | output | 1 | Completion record valid |
| cpl_status_o | output | 2 | 0 done, 1 timeout, 2 sequence error, 3 send error |
| cpl_seq_o | output | 16 | Sequence ID of the completed command |
| cpl_prim_o | output | 16 | Primary status from the response, else 0 |
| cpl_words_o | output | 256 | Response words on a response completion, else 0 |

## Verification
Each bus request appears one cycle after the state that issues it. The bench's mailbox model acknowledges on the next falling edge. A completion therefore shows up one cycle after the acknowledge of the final doorbell-clear write, or one cycle after the timer reaches its limit. The bench samples on falling edges only. Instead of counting fixed cycles, it waits on events: doorbell writes seen by the model, and completion pulses caught by a monitor. The exceptions are the two checks that depend on time. The timeout check records the cycle of the doorbell write and expects the completion between `TIMEOUT_CYC` and `TIMEOUT_CYC`+4 cycles later. The pause check expects the next doorbell write between `PAUSE_CYC` and `PAUSE_CYC`+16 cycles after the third failure.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;
  localparam int WORD_W = 64;
  localparam int NWORDS = 4;
  localparam int ADDR_W = 4;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [ADDR_W-1:0] A_OUT0   = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT_DB = 4'd4;
  localparam logic [ADDR_W-1:0] A_IN0    = 4'd5;
  localparam logic [ADDR_W-1:0] A_IN_DB  = 4'd9;
  localparam logic [ADDR_W-1:0] A_IN_CLR = 4'd10;

  localparam int DB_ACK = 0;
  localparam int DB_RSP = 1;
  localparam int DB_RST = 2;

  localparam int HDR_SEQ_LSB = 16;
  localparam int HDR_RSPREQ  = 32;
  localparam int HDR_ACKREQ  = 33;
  localparam int PRIM_LSB    = 48;

  typedef enum logic [1:0] {
    CPL_DONE     = 2'd0,
    CPL_TIMEOUT  = 2'd1,
    CPL_SEQ_ERR  = 2'd2,
    CPL_SEND_ERR = 2'd3
  } cpl_status_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_DB_RD, ST_RSP, ST_CLR
  } seq_st_e;

  typedef enum logic [1:0] {CK_ACK, CK_RSP, CK_RST, CK_OTH} clr_kind_e;
endpackage

// File: rtl/mbox_cmd_fifo.sv
module mbox_cmd_fifo #(
  parameter int W     = 256,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0] cnt_q;

  assign full_o  = cnt_q == (AW+1)'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i && !full_o) wr_q <= nxt(wr_q);
      if (pop_i && !empty_o) rd_q <= nxt(rd_q);
      case ({push_i && !full_o, pop_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/mbox_seq_gen.sv
module mbox_seq_gen #(
  parameter logic [15:0] SEQ_LAST = 16'hFFFE
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  output logic [15:0] seq_o
);
  logic [15:0] seq_q;
  assign seq_o = seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seq_q <= 16'd1;
    else if (adv_i) seq_q <= (seq_q >= SEQ_LAST) ? 16'd1 : seq_q + 16'd1;
  end
endmodule

// File: rtl/mbox_cyc_timer.sv
module mbox_cyc_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic exp_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign exp_o = cnt_q == CW'(LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && !exp_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int          FIFO_DEPTH  = 4,
  parameter int unsigned TIMEOUT_CYC = 100000,
  parameter int unsigned PAUSE_CYC   = 1024,
  parameter int unsigned MAX_FAILS   = 3,
  parameter logic [15:0] SEQ_LAST    = 16'hFFFE
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  output logic                     cmd_ready_o,
  input  logic [NWORDS*WORD_W-1:0] cmd_words_i,
  output logic                     reg_req_o,
  output logic                     reg_we_o,
  output logic [ADDR_W-1:0]        reg_addr_o,
  output logic [WORD_W-1:0]        reg_wdata_o,
  input  logic                     reg_ack_i,
  input  logic                     reg_err_i,
  input  logic [WORD_W-1:0]        reg_rdata_i,
  input  logic                     irq_i,
  output logic                     cpl_valid_o,
  output logic [1:0]               cpl_status_o,
  output logic [15:0]              cpl_seq_o,
  output logic [15:0]              cpl_prim_o,
  output logic [NWORDS*WORD_W-1:0] cpl_words_o
);
  localparam int FW = NWORDS * WORD_W;
  localparam int FAIL_W = $clog2(MAX_FAILS + 1);

  seq_st_e     st_q;
  clr_kind_e   kind_q;
  logic [2:0]  idx_q;
  logic        wait_q, fire;
  word_t       held_q [NWORDS];
  word_t       rsp_q  [NWORDS];
  logic        held_v_q, sent_q, rsp_got_q, inflight;
  word_t       mask_q;
  logic [FAIL_W-1:0] fail_q;
  logic        pause_q, pause_start, pause_exp, tmo_exp, tmo_clr;

  logic          fifo_empty, fifo_full, pop;
  logic [FW-1:0] fifo_data;
  logic [15:0]   seq_cur;
  word_t         hdr_new;

  logic          cpl_set, cpl_rsp;
  cpl_status_e   cpl_code;
  logic          cpl_v_q;
  cpl_status_e   cpl_st_q;
  logic [15:0]   cpl_seq_q, cpl_prim_q;
  word_t         cpl_w_q [NWORDS];

  seq_st_e ret_st;

  assign cmd_ready_o = !fifo_full;
  assign fire        = wait_q && reg_ack_i;
  assign inflight    = held_v_q && sent_q;
  assign ret_st      = inflight ? ST_WAIT : ST_IDLE;
  assign pop         = (st_q == ST_IDLE) && !irq_i && !pause_q && !held_v_q && !fifo_empty;
  assign tmo_clr     = (st_q == ST_SEND) && fire && !reg_err_i && (idx_q == 3'd4);
  assign pause_start = (st_q == ST_SEND) && fire && reg_err_i && (fail_q == FAIL_W'(MAX_FAILS - 1));

  always_comb begin
    hdr_new = fifo_data[WORD_W-1:0];
    hdr_new[HDR_SEQ_LSB +: 16] = seq_cur;
    hdr_new[HDR_ACKREQ] = 1'b1;
  end

  mbox_cmd_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (cmd_valid_i),
    .data_i (cmd_words_i),
    .full_o (fifo_full),
    .pop_i  (pop),
    .empty_o(fifo_empty),
    .data_o (fifo_data)
  );

  mbox_seq_gen #(.SEQ_LAST(SEQ_LAST)) u_seq (
    .clk_i, .rst_ni, .adv_i(pop), .seq_o(seq_cur)
  );

  mbox_cyc_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_i, .rst_ni, .clr_i(tmo_clr), .run_i(inflight), .exp_o(tmo_exp)
  );

  mbox_cyc_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk_i, .rst_ni, .clr_i(pause_start), .run_i(pause_q), .exp_o(pause_exp)
  );

  // Bus request decode
  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = '0;
    reg_wdata_o = '0;
    unique case (st_q)
      ST_SEND: begin
        reg_req_o = !wait_q;
        reg_we_o  = 1'b1;
        if (idx_q == 3'd4) begin
          reg_addr_o  = A_OUT_DB;
          reg_wdata_o = 64'd1;
        end else begin
          reg_addr_o  = A_OUT0 + ADDR_W'(idx_q);
          reg_wdata_o = held_q[idx_q[1:0]];
        end
      end
      ST_DB_RD: begin
        reg_req_o  = !wait_q;
        reg_addr_o = A_IN_DB;
      end
      ST_RSP: begin
        reg_req_o  = !wait_q;
        reg_addr_o = A_IN0 + ADDR_W'(idx_q);
      end
      ST_CLR: begin
        reg_req_o   = !wait_q;
        reg_we_o    = 1'b1;
        reg_addr_o  = A_IN_CLR;
        reg_wdata_o = mask_q;
      end
      default: ;
    endcase
  end

  // Completion decode
  always_comb begin
    cpl_set  = 1'b0;
    cpl_rsp  = 1'b0;
    cpl_code = CPL_DONE;
    if ((st_q == ST_SEND) && fire && reg_err_i) begin
      cpl_set  = 1'b1;
      cpl_code = CPL_SEND_ERR;
    end
    if ((st_q == ST_WAIT) && !irq_i && tmo_exp) begin
      cpl_set  = 1'b1;
      cpl_code = CPL_TIMEOUT;
    end
    if ((st_q == ST_CLR) && fire && !reg_err_i && inflight) begin
      if ((kind_q == CK_ACK) && !held_q[0][HDR_RSPREQ]) cpl_set = 1'b1;
      if ((kind_q == CK_RSP) && rsp_got_q) begin
        cpl_set  = 1'b1;
        cpl_rsp  = 1'b1;
        cpl_code = (rsp_q[0][HDR_SEQ_LSB +: 16] == held_q[0][HDR_SEQ_LSB +: 16])
                   ? CPL_DONE : CPL_SEQ_ERR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= CK_OTH;
      idx_q     <= '0;
      wait_q    <= 1'b0;
      held_v_q  <= 1'b0;
      sent_q    <= 1'b0;
      rsp_got_q <= 1'b0;
      mask_q    <= '0;
      fail_q    <= '0;
      pause_q   <= 1'b0;
      for (int i = 0; i < NWORDS; i++) begin
        held_q[i] <= '0;
        rsp_q[i]  <= '0;
      end
    end else begin
      if (reg_req_o)      wait_q <= 1'b1;
      else if (reg_ack_i) wait_q <= 1'b0;
      if (pause_exp) pause_q <= 1'b0;
      if (cpl_set)   held_v_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: begin
          if (irq_i) st_q <= ST_DB_RD;
          else if (!pause_q && held_v_q) begin
            idx_q <= '0;
            st_q  <= ST_SEND;
          end else if (pop) begin
            held_q[0] <= hdr_new;
            for (int i = 1; i < NWORDS; i++) held_q[i] <= fifo_data[i*WORD_W +: WORD_W];
            held_v_q <= 1'b1;
            sent_q   <= 1'b0;
            idx_q    <= '0;
            st_q     <= ST_SEND;
          end
        end
        ST_SEND: if (fire) begin
          if (reg_err_i) begin
            if (pause_start) begin
              fail_q  <= '0;
              pause_q <= 1'b1;
            end else fail_q <= fail_q + 1'b1;
            st_q <= ST_IDLE;
          end else if (idx_q == 3'd4) begin
            sent_q <= 1'b1;
            fail_q <= '0;
            st_q   <= ST_WAIT;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_WAIT: begin
          if (irq_i)        st_q <= ST_DB_RD;
          else if (tmo_exp) st_q <= ST_IDLE;
        end
        ST_DB_RD: if (fire) begin
          if (reg_err_i || reg_rdata_i == '0) st_q <= ret_st;
          else if (reg_rdata_i[DB_RST]) begin
            mask_q <= reg_rdata_i;
            kind_q <= CK_RST;
            st_q   <= ST_CLR;
          end else if (reg_rdata_i[DB_ACK]) begin
            mask_q <= word_t'(1) << DB_ACK;
            kind_q <= CK_ACK;
            st_q   <= ST_CLR;
          end else if (reg_rdata_i[DB_RSP]) begin
            if (inflight && held_q[0][HDR_RSPREQ]) begin
              idx_q <= '0;
              st_q  <= ST_RSP;
            end else begin
              mask_q <= word_t'(1) << DB_RSP;
              kind_q <= CK_RSP;
              st_q   <= ST_CLR;
            end
          end else begin
            mask_q <= reg_rdata_i & ~word_t'(7);
            kind_q <= CK_OTH;
            st_q   <= ST_CLR;
          end
        end
        ST_RSP: if (fire) begin
          if (reg_err_i) st_q <= ret_st;
          else begin
            rsp_q[idx_q[1:0]] <= reg_rdata_i;
            if (idx_q == 3'(NWORDS - 1)) begin
              rsp_got_q <= 1'b1;
              mask_q    <= word_t'(1) << DB_RSP;
              kind_q    <= CK_RSP;
              st_q      <= ST_CLR;
            end else idx_q <= idx_q + 1'b1;
          end
        end
        ST_CLR: if (fire) begin
          if (reg_err_i) st_q <= ret_st;
          else if (kind_q == CK_RST) begin
            sent_q    <= 1'b0;
            rsp_got_q <= 1'b0;
            st_q      <= ST_IDLE;
          end else begin
            if (kind_q == CK_RSP) rsp_got_q <= 1'b0;
            st_q <= ST_DB_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_v_q    <= 1'b0;
      cpl_st_q   <= CPL_DONE;
      cpl_seq_q  <= '0;
      cpl_prim_q <= '0;
      for (int i = 0; i < NWORDS; i++) cpl_w_q[i] <= '0;
    end else begin
      cpl_v_q <= cpl_set;
      if (cpl_set) begin
        cpl_st_q   <= cpl_code;
        cpl_seq_q  <= held_q[0][HDR_SEQ_LSB +: 16];
        cpl_prim_q <= cpl_rsp ? rsp_q[0][PRIM_LSB +: 16] : 16'd0;
        for (int i = 0; i < NWORDS; i++) cpl_w_q[i] <= cpl_rsp ? rsp_q[i] : '0;
      end
    end
  end

  assign cpl_valid_o  = cpl_v_q;
  assign cpl_status_o = cpl_st_q;
  assign cpl_seq_o    = cpl_seq_q;
  assign cpl_prim_o   = cpl_prim_q;

  for (genvar g = 0; g < NWORDS; g++) begin : g_cpl_words
    assign cpl_words_o[g*WORD_W +: WORD_W] = cpl_w_q[g];
  end
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk #(
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_req_o,
  input logic        reg_we_o,
  input logic [3:0]  reg_addr_o,
  input logic [63:0] reg_wdata_o,
  input logic        reg_ack_i,
  input logic        reg_err_i,
  input logic        cpl_valid_o,
  input logic [1:0]  cpl_status_o
);
  logic        pend_q, dbw_q, outst_q;
  logic [31:0] cnt_q;
  logic        db_set_req, rst_clr_req;

  assign db_set_req  = reg_req_o && reg_we_o && (reg_addr_o == 4'd4);
  assign rst_clr_req = reg_req_o && reg_we_o && (reg_addr_o == 4'd10) && reg_wdata_o[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      dbw_q   <= 1'b0;
      outst_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (reg_req_o)      pend_q <= 1'b1;
      else if (reg_ack_i) pend_q <= 1'b0;
      if (db_set_req)     dbw_q <= 1'b1;
      else if (reg_ack_i) dbw_q <= 1'b0;
      if (dbw_q && reg_ack_i && !reg_err_i) begin
        outst_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        if (cpl_valid_o || rst_clr_req) outst_q <= 1'b0;
        if (cnt_q != 32'hFFFF_FFFF) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R13
  one_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> !pend_q);

  // R4
  single_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_set_req |-> !outst_q);

  // R9
  tmo_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && cpl_status_o == 2'd1) |-> (cnt_q >= TIMEOUT_CYC));

  // R5
  cpl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |=> !cpl_valid_o);
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i, .rst_ni, .reg_req_o, .reg_we_o, .reg_addr_o, .reg_wdata_o,
  .reg_ack_i, .reg_err_i, .cpl_valid_o, .cpl_status_o
);

// File: tb/mbox_cmd_seq_test.sv
module mbox_cmd_seq_test;
  localparam int TMO   = 60;
  localparam int PAUSE = 40;
  localparam logic [15:0] SLAST = 16'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [255:0] cmd_words = '0;
  logic reg_req, reg_we, reg_ack = 1'b0, reg_err = 1'b0, irq;
  logic [3:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata = '0;
  logic cpl_valid;
  logic [1:0] cpl_status;
  logic [15:0] cpl_seq, cpl_prim;
  logic [255:0] cpl_words;

  mbox_cmd_seq #(.FIFO_DEPTH(4), .TIMEOUT_CYC(TMO), .PAUSE_CYC(PAUSE), .SEQ_LAST(SLAST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_words_i(cmd_words), .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_ack_i(reg_ack), .reg_err_i(reg_err), .reg_rdata_i(reg_rdata),
    .irq_i(irq), .cpl_valid_o(cpl_valid), .cpl_status_o(cpl_status), .cpl_seq_o(cpl_seq),
    .cpl_prim_o(cpl_prim), .cpl_words_o(cpl_words)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc++;

  // mailbox engine model
  logic [63:0] out_w [4];
  logic [63:0] in_w  [4];
  logic [63:0] in_db = '0;
  int db_writes = 0, db_cyc = 0, rsp_rd_n = 0, clr_n = 0, clr_rsp_rd = 0;
  logic [63:0] clr_hist [8];
  logic [63:0] last_w0 = '0;
  bit err_wr = 1'b0, set_tog = 1'b0, seen_tog = 1'b0;
  logic [63:0] set_bits = '0;
  bit pend = 1'b0, p_we;
  logic [3:0] p_addr;
  logic [63:0] p_wd;

  assign irq = |in_db;

  always @(negedge clk) begin
    reg_ack = 1'b0;
    reg_err = 1'b0;
    if (pend) begin
      pend = 1'b0;
      reg_ack = 1'b1;
      if (p_we) begin
        if (p_addr <= 4'd4 && err_wr) reg_err = 1'b1;
        else if (p_addr < 4'd4) out_w[p_addr[1:0]] = p_wd;
        else if (p_addr == 4'd4) begin
          db_writes++; db_cyc = cyc; last_w0 = out_w[0];
        end else if (p_addr == 4'd10) begin
          if (clr_n < 8) clr_hist[clr_n] = p_wd;
          clr_n++;
          if (p_wd[1]) begin clr_rsp_rd = rsp_rd_n; rsp_rd_n = 0; end
          in_db = in_db & ~p_wd;
        end
      end else begin
        if (p_addr == 4'd9) reg_rdata = in_db;
        else if (p_addr >= 4'd5 && p_addr <= 4'd8) begin
          reg_rdata = in_w[p_addr - 4'd5]; rsp_rd_n++;
        end else reg_rdata = '0;
      end
    end
    if (set_tog != seen_tog) begin in_db = in_db | set_bits; seen_tog = set_tog; end
    if (reg_req) begin pend = 1'b1; p_we = reg_we; p_addr = reg_addr; p_wd = reg_wdata; end
  end

  // completion monitor
  int cpl_cnt = 0, cpl_cyc = 0;
  logic [1:0] m_st; logic [15:0] m_seq, m_prim; logic [255:0] m_words;
  always @(negedge clk) if (cpl_valid) begin
    cpl_cnt++; cpl_cyc = cyc; m_st = cpl_status; m_seq = cpl_seq; m_prim = cpl_prim; m_words = cpl_words;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nseq(input logic [15:0] s);
    return (s >= SLAST) ? 16'd1 : s + 16'd1;
  endfunction

  function automatic logic [63:0] exp_w0(input logic [63:0] h, input logic [15:0] s);
    return {h[63:34], 1'b1, h[32], s, h[15:0]};
  endfunction

  logic [15:0] eseq = 16'd1;

  task automatic ring(input logic [63:0] b);
    @(posedge clk); #2;
    set_bits = b; set_tog = ~set_tog;
  endtask

  task automatic push(input logic [63:0] h, input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    @(posedge clk); #2;
    cmd_words = {c, b, a, h}; cmd_valid = 1'b1;
    while (!cmd_ready) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_db(input int prev, input string req);
    int n = 0;
    while (db_writes == prev && n < 400) begin @(posedge clk); #2; n++; end
    chk(db_writes != prev, req, 64'(db_writes), 64'(prev + 1));
  endtask

  task automatic wait_cpl(input int prev, input string req);
    int n = 0;
    while (cpl_cnt == prev && n < 400) begin @(posedge clk); #2; n++; end
    chk(cpl_cnt != prev, req, 64'(cpl_cnt), 64'(prev + 1));
  endtask

  task automatic wait_clr;
    int n = 0;
    while (in_db != 0 && n < 200) begin @(posedge clk); #2; n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int d, c;
    logic [63:0] h, w1, w2, w3;
    logic [15:0] s;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin out_w[i] = '0; in_w[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    // R1
    chk(cmd_ready === 1'b1, "R1 ready", 64'(cmd_ready), 64'd1);
    chk(cpl_valid === 1'b0, "R1 cpl_valid", 64'(cpl_valid), 64'd0);
    chk(reg_req === 1'b0, "R1 reg_req", 64'(reg_req), 64'd0);
    rst_n = 1'b1;

    // R2 R3 R5: ack-only command
    d = db_writes; c = cpl_cnt;
    h = 64'hA5A5_0000_FFFF_1234;
    push(h, 64'h11, 64'h22, 64'h33);
    wait_db(d, "R2 send");
    chk(last_w0 == exp_w0(h, eseq), "R2 R3 word0", last_w0, exp_w0(h, eseq));
    chk(out_w[1] == 64'h11 && out_w[3] == 64'h33, "R2 data words", out_w[3], 64'h33);
    ring(64'h1);
    wait_cpl(c, "R5 cpl");
    chk(m_st == 2'd0 && m_seq == eseq, "R5 done", {m_st, m_seq}, {2'd0, eseq});
    eseq = nseq(eseq);

    // R6 R7: ack and response together
    d = db_writes; c = cpl_cnt;
    h = 64'h0000_0001_0000_0042;
    push(h, 64'h1, 64'h2, 64'h3);
    wait_db(d, "R6 send");
    in_w[0] = {16'h00AB, 16'h0, eseq, 16'h0042};
    in_w[1] = 64'hDEAD; in_w[2] = 64'hBEEF; in_w[3] = 64'hCAFE;
    clr_n = 0;
    ring(64'h3);
    wait_cpl(c, "R6 cpl");
    chk(m_st == 2'd0 && m_prim == 16'h00AB, "R6 status prim", {m_st, m_prim}, {2'd0, 16'h00AB});
    chk(m_words == {in_w[3], in_w[2], in_w[1], in_w[0]}, "R6 words", m_words[63:0], in_w[0]);
    chk(clr_rsp_rd == 4, "R6 read before clear", 64'(clr_rsp_rd), 64'd4);
    chk(clr_hist[0] == 64'h1, "R7 ack cleared first", clr_hist[0], 64'h1);
    eseq = nseq(eseq);

    // R8: sequence mismatch
    d = db_writes; c = cpl_cnt;
    push(64'h0000_0001_0000_0007, 0, 0, 0);
    wait_db(d, "R8 send");
    in_w[0] = {16'h0001, 16'h0, 16'hBEEF, 16'h0007};
    ring(64'h3);
    wait_cpl(c, "R8 cpl");
    chk(m_st == 2'd2, "R8 seq error", 64'(m_st), 64'd2);
    eseq = nseq(eseq);

    // R4: second command held back
    d = db_writes; c = cpl_cnt;
    push(64'h0000_0001_0000_0100, 0, 0, 0);
    push(64'h0000_0000_0000_0200, 0, 0, 0);
    wait_db(d, "R4 first send");
    repeat (30) @(posedge clk);
    #2;
    chk(db_writes == d + 1, "R4 single in flight", 64'(db_writes), 64'(d + 1));
    in_w[0] = {16'h0, 16'h0, eseq, 16'h0100};
    ring(64'h3);
    wait_cpl(c, "R4 first cpl");
    eseq = nseq(eseq);
    wait_db(d + 1, "R4 second send");
    chk(last_w0[31:16] == eseq, "R3 R4 second seq", 64'(last_w0[31:16]), 64'(eseq));
    ring(64'h1);
    wait_cpl(c + 1, "R4 second cpl");
    eseq = nseq(eseq);

    // R9: timeout
    d = db_writes; c = cpl_cnt;
    push(64'h0000_0001_0000_0300, 0, 0, 0);
    wait_db(d, "R9 send");
    ring(64'h1);
    begin
      int n = 0;
      while (cpl_cnt == c && n < 400) begin @(posedge clk); #2; n++; end
    end
    chk(cpl_cnt == c + 1 && m_st == 2'd1, "R9 timeout status", 64'(m_st), 64'd1);
    chk((cpl_cyc - db_cyc) >= TMO && (cpl_cyc - db_cyc) <= TMO + 4, "R9 timeout window",
        64'(cpl_cyc - db_cyc), 64'(TMO));
    eseq = nseq(eseq);

    // R10: back from reset
    d = db_writes; c = cpl_cnt;
    push(64'h0000_0000_0000_0400, 0, 0, 0);
    wait_db(d, "R10 send");
    s = last_w0[31:16];
    ring(64'h5);
    wait_db(d + 1, "R10 resend");
    chk(in_db == 0, "R10 bits cleared", in_db, 64'h0);
    chk(last_w0[31:16] == s && s == eseq, "R10 same seq", 64'(last_w0[31:16]), 64'(eseq));
    chk(cpl_cnt == c, "R10 no cpl on reset", 64'(cpl_cnt), 64'(c));
    ring(64'h1);
    wait_cpl(c, "R10 cpl");
    chk(m_st == 2'd0, "R10 done after resend", 64'(m_st), 64'd0);
    eseq = nseq(eseq);

    // R12: stray bits while idle
    d = db_writes; c = cpl_cnt;
    ring(64'h102);
    repeat (25) @(posedge clk);
    #2;
    chk(in_db == 0, "R12 stray cleared", in_db, 64'h0);
    chk(cpl_cnt == c && db_writes == d, "R12 no cpl", 64'(cpl_cnt), 64'(c));

    // R11: send errors and pause
    d = db_writes; c = cpl_cnt;
    err_wr = 1'b1;
    for (int i = 0; i < 4; i++) push(64'h0000_0000_0000_0500 + 64'(i), 0, 0, 0);
    begin
      int n = 0;
      while (cpl_cnt < c + 3 && n < 400) begin @(posedge clk); #2; n++; end
    end
    err_wr = 1'b0;
    chk(cpl_cnt == c + 3 && m_st == 2'd3, "R11 send errors", 64'(m_st), 64'd3);
    eseq = nseq(nseq(nseq(eseq)));
    wait_db(d, "R11 resume");
    chk((db_cyc - cpl_cyc) >= PAUSE && (db_cyc - cpl_cyc) <= PAUSE + 16, "R11 pause gap",
        64'(db_cyc - cpl_cyc), 64'(PAUSE));
    chk(last_w0[31:16] == eseq, "R3 seq after errors", 64'(last_w0[31:16]), 64'(eseq));
    ring(64'h1);
    wait_cpl(c + 3, "R11 final cpl");
    eseq = nseq(eseq);

    // random traffic, includes R3 wrap at SEQ_LAST
    for (int k = 0; k < 16; k++) begin
      bit rr, comb;
      logic [15:0] prim;
      d = db_writes; c = cpl_cnt;
      rr = 1'($urandom);
      h = {$urandom, $urandom};
      h[32] = rr;
      w1 = {$urandom, $urandom}; w2 = {$urandom, $urandom}; w3 = {$urandom, $urandom};
      push(h, w1, w2, w3);
      wait_db(d, "R2 rand send");
      chk(last_w0 == exp_w0(h, eseq), "R2 R3 rand word0", last_w0, exp_w0(h, eseq));
      chk(out_w[2] == w2, "R2 rand word2", out_w[2], w2);
      repeat ($urandom % 6) @(posedge clk);
      if (!rr) begin
        ring(64'h1);
        wait_cpl(c, "R5 rand cpl");
        chk(m_st == 2'd0 && m_seq == eseq, "R5 rand done", {m_st, m_seq}, {2'd0, eseq});
      end else begin
        prim = 16'($urandom);
        in_w[0] = {prim, 16'($urandom), eseq, 16'($urandom)};
        in_w[1] = {$urandom, $urandom}; in_w[2] = {$urandom, $urandom}; in_w[3] = {$urandom, $urandom};
        comb = 1'($urandom);
        if (comb) ring(64'h3);
        else begin
          ring(64'h1);
          @(posedge clk); #2;
          wait_clr;
          ring(64'h2);
        end
        wait_cpl(c, "R6 rand cpl");
        chk(m_st == 2'd0 && m_prim == prim && m_seq == eseq, "R6 rand status",
            {m_st, m_prim, m_seq}, {2'd0, prim, eseq});
        chk(m_words == {in_w[3], in_w[2], in_w[1], in_w[0]}, "R6 rand words",
            m_words[255:192], in_w[3]);
      end
      eseq = nseq(eseq);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule